// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the data side of a small accumulator-style processor. One n-bit bus links four general registers, a hidden operand latch and a hidden result register. An external sequencer drives every control line directly. Per register, it drives an output enable that places the register's value on the bus and a load enable that captures the bus on the next rising edge. It also drives output enables for the result register and for an external data word. It drives load enables for the operand latch and the result register, and a subtract select for the arithmetic unit.

Arithmetic takes several cycles:

1. The first operand is copied from the bus into the hidden operand latch.
2. The second operand is placed on the bus while the result register captures the sum or difference.
3. The result register is driven onto the bus and loaded into a general register.

A plain move between two general registers takes one edge. Enable the source's output and the destination's load in the same cycle.

The bus is a per-bit multiplexer, not a set of tri-state drivers. The external word is one more selectable source.

Top module: `bus_datapath`

## Requirements
- R1: A synchronous active-high reset clears the four general registers, the operand latch and the result register to zero.
- R2: The sequencer asserts at most one of the six output enables (four register enables, the result enable, the external enable) in any cycle. With none asserted, the bus reads all zeros.
- R3: A general register whose load enable is high takes the bus value at the next rising edge.
- R4: A general register whose load enable is low keeps its value across edges.
- R5: When the external enable is high, the bus carries the external data word.
- R6: When its load enable is high, the operand latch takes the bus value at the next rising edge.
- R7: When its load enable is high, the result register takes operand + bus with subtract low, and operand − bus (modulo 2^W) with subtract high. Both results keep W bits and discard the carry.
- R8: The result register holds its value while its load enable is low. It reaches the bus only through its own output enable.
- R9: A move between general registers completes in one edge: the destination gets the source's value and the source is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_data | input | W | External data word |
| ext_oe | input | 1 | Place external data on the bus |
| reg_oe | input | NREG | Per-register bus output enable, bit i for register i |
| reg_ld | input | NREG | Per-register load enable, bit i for register i |
| opnd_ld | input | 1 | Load the bus into the operand latch |
| res_ld | input | 1 | Load the arithmetic result into the result register |
| res_oe | input | 1 | Place the result register on the bus |
| sub | input | 1 | 1 selects subtraction, 0 selects addition |
| bus_out | output | W | Current bus value |

## Verification
On every cycle, the embedded assertions check four things:
- The output enables are exclusive, and an idle bus reads zero.
- Each loaded register or latch holds the bus value from the previous cycle, and an unloaded one stays unchanged.
- The result register holds the wrapped sum or difference of the operand latch and the previous bus value.
- The result register keeps its value while its load enable is low.

The bench's directed scenarios show the rest through the bus alone:
- The reset values.
- The use of external data.
- A one-edge move that leaves its source intact.
- Additions and subtractions that wrap past the top or below zero.

The random sequences then chain loads, moves and arithmetic against a model of all six registers.

// File: rtl/bus_datapath.sv
module bus_datapath #(
  parameter int W    = 8,
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    ext_data,
  input  logic            ext_oe,
  input  logic [NREG-1:0] reg_oe,
  input  logic [NREG-1:0] reg_ld,
  input  logic            opnd_ld,
  input  logic            res_ld,
  input  logic            res_oe,
  input  logic            sub,
  output logic [W-1:0]    bus_out
);

  logic [W-1:0] rq [NREG];
  logic [W-1:0] a_q, g_q;
  logic [W-1:0] bus;
  logic [W-1:0] b_op, alu_y;

  always_comb begin
    bus = '0;
    if (ext_oe) bus = ext_data;
    if (res_oe) bus = g_q;
    for (int i = 0; i < NREG; i++)
      if (reg_oe[i]) bus = rq[i];
  end

  assign bus_out = bus;

  assign b_op  = bus ^ {W{sub}};
  assign alu_y = a_q + b_op + {{(W-1){1'b0}}, sub};

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)            rq[i] <= '0;
        else if (reg_ld[i]) rq[i] <= bus;
      end

      a_r3_load: assert property (@(posedge clk) disable iff (rst)
        reg_ld[i] |=> rq[i] == $past(bus_out));
      a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_ld[i] |=> rq[i] == $past(rq[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          a_q <= '0;
    else if (opnd_ld) a_q <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst)         g_q <= '0;
    else if (res_ld) g_q <= alu_y;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_oe, res_oe, ext_oe}));
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (reg_oe == '0 && !res_oe && !ext_oe) |-> bus_out == '0);
  a_r6_opnd: assert property (@(posedge clk) disable iff (rst)
    opnd_ld |=> a_q == $past(bus_out));
  a_r7_add: assert property (@(posedge clk) disable iff (rst)
    (res_ld && !sub) |=> g_q == W'($past(a_q) + $past(bus_out)));
  a_r7_sub: assert property (@(posedge clk) disable iff (rst)
    (res_ld && sub) |=> g_q == W'($past(a_q) - $past(bus_out)));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !res_ld |=> $stable(g_q));

endmodule

// File: tb/sim_bus_datapath.sv
module sim_bus_datapath;
  localparam int W = 8;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] ext_data = '0;
  logic ext_oe = 1'b0, opnd_ld = 1'b0, res_ld = 1'b0, res_oe = 1'b0, sub = 1'b0;
  logic [N-1:0] reg_oe = '0, reg_ld = '0;
  logic [W-1:0] bus_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_r [N];
  logic [W-1:0] m_a, m_g;

  always #2 clk = ~clk;

  bus_datapath #(.W(W), .NREG(N)) u0 (
    .clk(clk), .rst(rst), .ext_data(ext_data), .ext_oe(ext_oe),
    .reg_oe(reg_oe), .reg_ld(reg_ld), .opnd_ld(opnd_ld), .res_ld(res_ld),
    .res_oe(res_oe), .sub(sub), .bus_out(bus_out)
  );

  function automatic logic [W-1:0] model_bus();
    logic [W-1:0] v = '0;
    if (ext_oe) v = ext_data;
    if (res_oe) v = m_g;
    for (int i = 0; i < N; i++) if (reg_oe[i]) v = m_r[i];
    return v;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] ed, input logic eoe, input logic [N-1:0] roe,
                      input logic [N-1:0] rld, input logic ald, input logic gld,
                      input logic goe, input logic sb, input string tag);
    logic [W-1:0] bv;
    @(negedge clk);
    ext_data = ed; ext_oe = eoe; reg_oe = roe; reg_ld = rld;
    opnd_ld = ald; res_ld = gld; res_oe = goe; sub = sb;
    #1;
    bv = model_bus();
    check(bus_out, bv, tag);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (rld[i]) m_r[i] = bv;
    if (gld) m_g = sb ? W'(m_a - bv) : W'(m_a + bv);
    if (ald) m_a = bv;
  endtask

  task automatic rd(input int i, input string tag);
    step('0, 1'b0, N'(1 << i), '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    int unsigned seed;
    for (int i = 0; i < N; i++) m_r[i] = '0;
    m_a = '0; m_g = '0;
    repeat (3) @(posedge clk);
    #1;
    check(bus_out, '0, "R2 idle bus during reset");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < N; i++) rd(i, "R1 general register reset value");
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 result register reset value");
    step('0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 idle bus");
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 operand latch reset value");

    step(8'h5A, 1'b1, '0, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, "R5 external data on bus");
    rd(2, "R3 register 2 loaded from external");
    repeat (3) step(8'hFF, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle with ext_data but no enable");
    rd(2, "R4 register 2 held");
    rd(0, "R4 register 0 untouched");

    step('0, 1'b0, 4'b0100, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, "R9 move register 2 to 0");
    rd(0, "R9 destination after move");
    rd(2, "R9 source after move");

    step(8'hF0, 1'b1, '0, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, "R5 load F0");
    step(8'h20, 1'b1, '0, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, "R5 load 20");
    step('0, 1'b0, 4'b0010, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 operand from register 1");
    step('0, 1'b0, 4'b1000, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 add F0+20");
    step('0, 1'b0, '0, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, "R7 wrapped sum 10 on bus");
    rd(0, "R7 register 0 got wrapped sum");

    step(8'h05, 1'b1, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 operand from external 05");
    step(8'h07, 1'b1, '0, '0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 subtract 05-07");
    repeat (2) step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 result hidden without enable");
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 result held FE");
    check(m_g, 8'hFE, "R7 bench model difference");

    seed = $urandom(32'd281);
    for (int k = 0; k < 400; k++) begin
      int unsigned src = $urandom % 7;
      logic [N-1:0] roe = '0;
      logic e = 1'b0, go = 1'b0;
      if (src < N) roe[src] = 1'b1;
      else if (src == N) go = 1'b1;
      else if (src == N + 1) e = 1'b1;
      step(W'($urandom), e, roe, N'($urandom), 1'($urandom), 1'($urandom), go,
           1'($urandom), "R3 R7 R9 random sequence");
    end
    for (int i = 0; i < N; i++) rd(i, "R4 final register contents");
    step('0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 final result contents");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule